// File: doc/BRIEF.md
# Conditional Branch and Next-PC Unit

This block owns the program counter of a 16-bit word-addressed processor and decides, one load at a time, where the counter goes next. During fetch the controller asks for the counter plus one. During execution of a conditional branch the block tests the instruction's three-bit condition mask against the current negative/zero/positive flags. When any requested flag is set, it loads a target formed by adding the sign-extended 9-bit offset to the counter, which fetch has already advanced. A register jump loads the counter from a base register value supplied by the register file. A third source takes a full 16-bit value from the shared data bus.

The controller supplies a load strobe and a two-bit source select. The block reports the current counter and a combinational taken indication. That indication is derived from the instruction word and the flags alone, so the controller can use it in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset sets `pc` to the parameter `RESET_PC` (default 16'h3000) on the next clock edge, whatever the load strobe and source select are doing.
- R2: While `pc_load` is 0, `pc` keeps its value whatever the other inputs do.
- R3: With `pc_load`=1 and `pc_sel`=2'b00 (increment), `pc` becomes `pc`+1 modulo 2^16, so 16'hFFFF wraps to 16'h0000.
- R4: An instruction whose bits [15:12] are 4'b0000 is a conditional branch. Its mask is bits [11:9], with bit 11 testing n, bit 10 testing z and bit 9 testing p. `cc_flags` carries n in bit 2, z in bit 1 and p in bit 0. For a branch, `taken` is 1 exactly when some mask bit and its matching flag are both 1. A mask of 3'b000 therefore never branches, and 3'b111 always branches while a flag is set.
- R5: With `pc_load`=1, `pc_sel`=2'b01 (address adder) and a taken branch, `pc` becomes `pc` plus the sign extension of bits [8:0], modulo 2^16.
- R6: With `pc_load`=1, `pc_sel`=2'b01 and a branch that is not taken, `pc` is unchanged, so it still addresses the next sequential instruction.
- R7: An instruction whose bits [15:12] are 4'b1100 is a register jump. `taken` is 1 for it regardless of the flags. With `pc_load`=1 and `pc_sel`=2'b01, `pc` becomes `base_val`, which is the base plus a zero offset.
- R8: For any opcode other than branch or jump, `taken` is 0, and `pc_sel`=2'b01 leaves `pc` unchanged.
- R9: With `pc_load`=1 and `pc_sel`=2'b10 (bus), `pc` becomes `bus_val`, whatever the instruction and `taken` are.
- R10: With `pc_load`=1 and `pc_sel`=2'b11, `pc` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word being executed |
| cc_flags | input | 3 | Condition flags {n, z, p} |
| base_val | input | 16 | Base register value for register jumps |
| bus_val | input | 16 | Value on the shared data bus |
| pc_load | input | 1 | Load strobe for the program counter |
| pc_sel | input | 2 | Source select: 00 increment, 01 adder, 10 bus, 11 hold |
| pc | output | 16 | Program counter |
| taken | output | 1 | Branch or jump is taken for the current instruction |

## Verification
The branch decision and the counter update can fall in the same cycle. A taken branch or jump may be on `instr` while the controller selects the increment or bus source, or while it withholds the load strobe. The bench drives every opcode class with all 64 mask/flag pairs. In each of those cycles it checks that `taken` follows the mask rule, and that `pc` follows only the selected source. For example, a taken branch under bus select must load the bus value, and an untaken branch under adder select must leave `pc` in place.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int INSTR_W = 16;
    localparam int OFF_W   = 9;
    localparam int CC_W    = 3;

    localparam logic [3:0] OP_BRANCH = 4'b0000;
    localparam logic [3:0] OP_JUMP   = 4'b1100;

    typedef enum logic [1:0] {
        SRC_INC  = 2'b00,
        SRC_ADDR = 2'b01,
        SRC_BUS  = 2'b10,
        SRC_HOLD = 2'b11
    } pc_src_e;

    typedef struct packed {
        logic              is_branch;
        logic              is_jump;
        logic [CC_W-1:0]   mask;
        logic [OFF_W-1:0]  offset;
    } ctl_dec_t;

    function automatic ctl_dec_t decode_ctl(input logic [INSTR_W-1:0] ir);
        ctl_dec_t d;
        d.is_branch = (ir[15:12] == OP_BRANCH);
        d.is_jump   = (ir[15:12] == OP_JUMP);
        d.mask      = ir[11:9];
        d.offset    = ir[OFF_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  logic [CC_W-1:0] mask,
    input  logic [CC_W-1:0] flags,
    output logic            match
);
    logic [CC_W-1:0] hit;

    for (genvar i = 0; i < CC_W; i++) begin : g_hit
        assign hit[i] = mask[i] & flags[i];
    end

    assign match = |hit;
endmodule

// File: rtl/npc_addr_adder.sv
module npc_addr_adder
    import npc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              use_base,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] lhs;
    logic [ADDR_W-1:0] rhs;

    always_comb begin
        if (use_base) begin
            lhs = base_val;
            rhs = '0;
        end else begin
            lhs = pc;
            rhs = {{EXT_W{offset[OFF_W-1]}}, offset};
        end
        sum = lhs + rhs;
    end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  pc_src_e           sel,
    input  logic              adder_ok,
    input  logic [ADDR_W-1:0] adder_val,
    input  logic [ADDR_W-1:0] bus_val,
    output logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_nxt;

    assign pc_inc = pc_q + ADDR_W'(1);

    always_comb begin
        pc_nxt = pc_q;
        if (load) begin
            unique case (sel)
                SRC_INC:  pc_nxt = pc_inc;
                SRC_ADDR: pc_nxt = adder_ok ? adder_val : pc_q;
                SRC_BUS:  pc_nxt = bus_val;
                SRC_HOLD: pc_nxt = pc_q;
                default:  pc_nxt = pc_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_nxt;
    end

    assign pc = pc_q;

    assert_no_load_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc_q));
    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (load && sel == SRC_INC) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));
    assert_bus_load_R9: assert property (@(posedge clk) disable iff (rst)
        (load && sel == SRC_BUS) |=> (pc_q == $past(bus_val)));
    assert_hold_code_R10: assert property (@(posedge clk) disable iff (rst)
        (load && sel == SRC_HOLD) |=> $stable(pc_q));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [CC_W-1:0]      cc_flags,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [ADDR_W-1:0]    bus_val,
    input  logic                 pc_load,
    input  logic [1:0]           pc_sel,
    output logic [ADDR_W-1:0]    pc,
    output logic                 taken
);
    ctl_dec_t          dec;
    logic              cond_hit;
    logic [ADDR_W-1:0] adder_sum;
    logic [ADDR_W-1:0] pc_cur;
    pc_src_e           src;

    assign dec = decode_ctl(instr);
    assign src = pc_src_e'(pc_sel);

    npc_cond u_cond (
        .mask  (dec.mask),
        .flags (cc_flags),
        .match (cond_hit)
    );

    assign taken = dec.is_jump | (dec.is_branch & cond_hit);

    npc_addr_adder #(.ADDR_W(ADDR_W)) u_adder (
        .use_base (dec.is_jump),
        .pc       (pc_cur),
        .base_val (base_val),
        .offset   (dec.offset),
        .sum      (adder_sum)
    );

    npc_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .load      (pc_load),
        .sel       (src),
        .adder_ok  (taken),
        .adder_val (adder_sum),
        .bus_val   (bus_val),
        .pc        (pc_cur)
    );

    assign pc = pc_cur;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (pc_cur == RESET_PC));
    assert_mask_none_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.is_branch && dec.mask == 3'b000) |-> !taken);
    assert_mask_all_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.is_branch && dec.mask == 3'b111 && cc_flags != 3'b000) |-> taken);
    assert_untaken_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && src == SRC_ADDR && dec.is_branch && (dec.mask & cc_flags) == 3'b000)
        |=> $stable(pc_cur));
    assert_jump_base_R7: assert property (@(posedge clk) disable iff (rst)
        (pc_load && src == SRC_ADDR && dec.is_jump) |=> (pc_cur == $past(base_val)));
    assert_other_op_R8: assert property (@(posedge clk) disable iff (rst)
        (!dec.is_branch && !dec.is_jump) |-> !taken);
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr;
    logic [2:0]  cc_flags;
    logic [15:0] base_val;
    logic [15:0] bus_val;
    logic        pc_load;
    logic [1:0]  pc_sel;
    logic [15:0] pc;
    logic        taken;

    int compared   = 0;
    int mismatched = 0;
    logic [15:0] exp_pc;

    always #2 clk = ~clk;

    npc_unit uut (
        .clk(clk), .rst(rst), .instr(instr), .cc_flags(cc_flags),
        .base_val(base_val), .bus_val(bus_val), .pc_load(pc_load),
        .pc_sel(pc_sel), .pc(pc), .taken(taken)
    );

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        report();
    end

    function automatic logic exp_taken(input logic [15:0] ir, input logic [2:0] f);
        if (ir[15:12] == 4'b0000) return (ir[11:9] & f) != 3'b000;
        if (ir[15:12] == 4'b1100) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk_pc(input string req, input logic [15:0] exp);
        compared++;
        if (pc !== exp) begin
            mismatched++;
            $display("FAIL %s: pc actual %h expected %h", req, pc, exp);
        end
    endtask

    // One clock: drive at negedge, check taken, then check pc after the edge.
    task automatic cyc(input string req, input logic r, input logic ld, input logic [1:0] sel,
                       input logic [15:0] ir, input logic [2:0] f,
                       input logic [15:0] bus, input logic [15:0] base);
        logic et;
        logic [15:0] nxt;
        @(negedge clk);
        rst = r; pc_load = ld; pc_sel = sel; instr = ir; cc_flags = f;
        bus_val = bus; base_val = base;
        #1;
        et = exp_taken(ir, f);
        compared++;
        if (taken !== et) begin
            mismatched++;
            $display("FAIL %s: taken actual %b expected %b (ir %h flags %b)", req, taken, et, ir, f);
        end
        nxt = exp_pc;
        if (r) nxt = 16'h3000;
        else if (ld) begin
            case (sel)
                2'b00: nxt = exp_pc + 16'd1;
                2'b01: begin
                    if (ir[15:12] == 4'b1100) nxt = base;
                    else if (et) nxt = exp_pc + {{7{ir[8]}}, ir[8:0]};
                end
                2'b10: nxt = bus;
                default: nxt = exp_pc;
            endcase
        end
        @(posedge clk);
        #1;
        exp_pc = nxt;
        chk_pc(req, exp_pc);
    endtask

    initial begin
        exp_pc = 16'h3000;
        rst = 1'b1; pc_load = 1'b0; pc_sel = 2'b00; instr = '0; cc_flags = '0;
        bus_val = '0; base_val = '0;
        // R1: reset state, and reset wins over a bus load
        cyc("R1", 1'b1, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0000, 16'h0000);
        cyc("R1", 1'b1, 1'b1, 2'b10, 16'h0E05, 3'b010, 16'hBEEF, 16'h1234);

        // R4 R8: full mask x flags sweep, no load (R2 holds pc meanwhile)
        for (int op = 0; op < 3; op++) begin
            for (int m = 0; m < 8; m++) begin
                for (int f = 0; f < 8; f++) begin
                    logic [3:0] opc;
                    opc = (op == 0) ? 4'b0000 : (op == 1) ? 4'b1100 : 4'b0001;
                    cyc("R2_R4_R8", 1'b0, 1'b0, 2'b01, {opc, 3'(m), 9'h0A5}, 3'(f),
                        16'hFFFF, 16'h7777);
                end
            end
        end

        // R5 R6: adder loads over many offsets; taken and not-taken
        for (int k = 0; k < 24; k++) begin
            logic [8:0] off;
            off = 9'((k * 37 + 256) & 9'h1FF);
            cyc("R9", 1'b0, 1'b1, 2'b10, 16'h1000, 3'b000, 16'((k * 2731) ^ 16'h4000), 16'h0);
            cyc("R5", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b111, off}, 3'b010, 16'h0, 16'h0);
            cyc("R6", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b100, off}, 3'b001, 16'h0, 16'h0);
            cyc("R6", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b000, off}, 3'b111, 16'h0, 16'h0);
            cyc("R5", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b011, off}, 3'b001, 16'h0, 16'h0);
        end
        // R5 wrap across the top and bottom of the address space
        cyc("R9", 1'b0, 1'b1, 2'b10, 16'h0000, 3'b000, 16'hFFF0, 16'h0);
        cyc("R5", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b001, 9'h020}, 3'b001, 16'h0, 16'h0);
        cyc("R5", 1'b0, 1'b1, 2'b01, {4'b0000, 3'b010, 9'h100}, 3'b010, 16'h0, 16'h0);

        // R3: increment and wrap
        cyc("R9", 1'b0, 1'b1, 2'b10, 16'h0000, 3'b000, 16'hFFFE, 16'h0);
        cyc("R3", 1'b0, 1'b1, 2'b00, 16'h0000, 3'b000, 16'h0, 16'h0);
        cyc("R3", 1'b0, 1'b1, 2'b00, 16'h0000, 3'b000, 16'h0, 16'h0);
        cyc("R3", 1'b0, 1'b1, 2'b00, 16'h5000, 3'b000, 16'h0, 16'h0);

        // R7: register jump, flags irrelevant
        cyc("R7", 1'b0, 1'b1, 2'b01, 16'hC1C0, 3'b000, 16'h0, 16'hA5A5);
        cyc("R7", 1'b0, 1'b1, 2'b01, 16'hC1FF, 3'b100, 16'h0, 16'h0001);
        // R8: other opcode under adder select holds
        cyc("R8", 1'b0, 1'b1, 2'b01, 16'h1E3F, 3'b111, 16'h0, 16'h9999);
        cyc("R8", 1'b0, 1'b1, 2'b01, 16'hEFFF, 3'b010, 16'h0, 16'h9999);

        // Same-cycle: taken decision with other sources selected
        cyc("R3", 1'b0, 1'b1, 2'b00, 16'h0E10, 3'b100, 16'h0, 16'h0);
        cyc("R9", 1'b0, 1'b1, 2'b10, 16'h0E10, 3'b100, 16'h2468, 16'h0);
        cyc("R9", 1'b0, 1'b1, 2'b10, 16'hC000, 3'b000, 16'h1357, 16'h8642);
        cyc("R2", 1'b0, 1'b0, 2'b01, 16'h0E10, 3'b100, 16'h0, 16'h0);
        cyc("R2", 1'b0, 1'b0, 2'b10, 16'hC000, 3'b000, 16'hDEAD, 16'hBEEF);
        // R10: hold code
        cyc("R10", 1'b0, 1'b1, 2'b11, 16'h0E10, 3'b100, 16'hDEAD, 16'hBEEF);
        cyc("R10", 1'b0, 1'b1, 2'b11, 16'hC000, 3'b000, 16'hDEAD, 16'hBEEF);
        // R1 again mid-run
        cyc("R1", 1'b1, 1'b1, 2'b00, 16'h0000, 3'b000, 16'h0, 16'h0);

        report();
    end
endmodule